// File: doc/BRIEF.md
# Three-Phase Dead-Time Generator

This block turns three phase commands (U, V, W) into six active-low gate drives, one positive and one negative drive for each phase. When a phase command changes level, the drive that was active is released at once. The drive that is about to become active waits until that phase's dead-time counter has run out. All three counters are 8-bit one-shots. They load from one shared reload register and decrement on a selectable tick. Because of this wait, the two drives of a pair are never low at the same time.

An output-enable latch gates the whole drive set. The six gate levels leave the block as registered values, and `gate_oe` serves as the common tristate enable for the pad buffers: 0 means every gate pin floats. The latch is cleared in four ways: by reset, by a software write of 0, by a falling edge on the NMI input after a two-stage synchroniser, and, when shoot-through protection is on, by both pad levels of one phase reading low. A small write port sets the reload value and the control bits.

Top module: `three_phase_deadtime`

## Requirements
- R1: While `rst` is high and on the edge after it, `gate_oe` is 0 and every gate output is 1. Reset also sets the reload value to 1, selects `tick_raw` as the count tick and turns protection off.
- R2: A write with `wr_sel`=0 loads `wr_data` into the shared reload register when the data is nonzero. A write of 0 is ignored, and the previous reload value stays in use.
- R3: When a phase command rises, the negative output of that phase goes high on the second edge after the command is sampled. The positive output goes low on the edge after the tick that brings the counter from the reload value down to 0.
- R4: When a phase command falls, the same rule applies with the roles swapped: the positive output goes high at once, and the negative output goes low after the counter expires.
- R5: A command change while the counter is still running reloads the counter from the current reload value. Both outputs of that phase stay high until the new count expires.
- R6: Control bit 1 selects the decrement tick: 0 selects `tick_raw` and 1 selects `tick_div2`. A counter holds its value in any cycle where the selected tick is 0.
- R7: The positive and negative outputs of one phase are never both 0 in the same cycle.
- R8: A write with `wr_sel`=1 sets the output-enable bit from data bit 0. `gate_oe` follows the write on the next edge. While it is 1 all six gates are driven; while it is 0 all six float.
- R9: A falling edge on `nmi_n` clears the output-enable bit on the third edge after the new level is first sampled. This clear wins over a software write of 1 on the same edge.
- R10: When control bit 2 is 1 and `pad_p_i[i]` and `pad_n_i[i]` are both 0 for some phase i at an edge, the output-enable bit is 0 after that edge, even against a write of 1. When bit 2 is 0, such pad levels have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = reload register, 1 = control register |
| wr_data | input | CNT_W | Write data; control bits are [0] enable, [1] tick select, [2] protection |
| tick_raw | input | 1 | Undivided count tick |
| tick_div2 | input | 1 | Half-rate count tick |
| phase_cmd | input | PHASES | Phase commands, bit 0 = U, 1 = V, 2 = W |
| nmi_n | input | 1 | Asynchronous emergency stop, active on its falling edge |
| pad_p_i | input | PHASES | Pad levels of the positive gates, read back |
| pad_n_i | input | PHASES | Pad levels of the negative gates, read back |
| gate_p_o | output | PHASES | Positive gate levels, active low |
| gate_n_o | output | PHASES | Negative gate levels, active low |
| gate_oe | output | 1 | Common pad drive enable; 0 floats all six gates |

## Verification
A phase command or tick is sampled on an edge. The counter reacts on that edge, and the gate registers show the change on the following edge. A released drive therefore appears two edges after the command changes, and an activated drive appears one edge after the tick that expires the count. `gate_oe` reflects a write or a protection trip one edge after it is sampled, and an NMI drop three edges after it is first sampled. The reference model advances on every rising edge in that same order, computing outputs from the state before the edge. The bench drives inputs and compares outputs on the falling edge, so every result is read exactly one half-period after the edge that produced it.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_CTRL   = 1'b1
  } wr_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRC_BIT  = 1;
  localparam int CTRL_PROT_BIT = 2;
  localparam int CTRL_BITS     = 3;
endpackage

// File: rtl/dt_regs.sv
module dt_regs
  import dt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload,
  output logic             src_div2,
  output logic             protect_en,
  output logic             en_wr,
  output logic             en_val
);
  localparam logic [CNT_W-1:0] RELOAD_RST = CNT_W'(1);

  logic wr_reload, wr_ctrl;
  assign wr_reload = wr_en && (wr_sel_e'(wr_sel) == SEL_RELOAD);
  assign wr_ctrl   = wr_en && (wr_sel_e'(wr_sel) == SEL_CTRL);
  assign en_wr     = wr_ctrl;
  assign en_val    = wr_data[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      reload     <= RELOAD_RST;
      src_div2   <= 1'b0;
      protect_en <= 1'b0;
    end else begin
      if (wr_reload && (wr_data != '0)) reload <= wr_data;
      if (wr_ctrl) begin
        src_div2   <= wr_data[CTRL_SRC_BIT];
        protect_en <= wr_data[CTRL_PROT_BIT];
      end
    end
  end

  assert_reload_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    reload != '0);
  assert_zero_write_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_reload && wr_data == '0) |=> $stable(reload));
endmodule

// File: rtl/dt_phase_timer.sv
module dt_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             gate_p_o,
  output logic             gate_n_o
);
  logic             cmd_d;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             edge_seen;

  assign edge_seen = (cmd != cmd_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_d    <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      gate_p_o <= 1'b1;
      gate_n_o <= 1'b1;
    end else begin
      gate_p_o <= ~(cmd_d & ~busy);
      gate_n_o <= ~(~cmd_d & ~busy);
      if (edge_seen) begin
        cmd_d <= cmd;
        cnt   <= reload;
        busy  <= (reload != '0);
      end else if (busy && tick) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  assert_busy_count_live_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
  assert_busy_holds_off_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (gate_p_o && gate_n_o));
  assert_retrigger_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && busy) |=> (cnt == $past(reload)));
  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!edge_seen && !tick) |=> $stable(cnt));
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(!gate_p_o && !gate_n_o));
endmodule

// File: rtl/dt_enable_ctrl.sv
module dt_enable_ctrl #(
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_n,
  input  logic [PHASES-1:0] pad_p_i,
  input  logic [PHASES-1:0] pad_n_i,
  input  logic              protect_en,
  input  logic              en_wr,
  input  logic              en_val,
  output logic              out_en
);
  logic [SYNC_STAGES:0] nmi_sh;
  logic                 nmi_fall;
  logic                 shoot;

  always_ff @(posedge clk) begin
    if (rst) nmi_sh <= '1;
    else     nmi_sh <= {nmi_sh[SYNC_STAGES-1:0], nmi_n};
  end

  assign nmi_fall = nmi_sh[SYNC_STAGES] & ~nmi_sh[SYNC_STAGES-1];
  assign shoot    = protect_en & (|(~pad_p_i & ~pad_n_i));

  always_ff @(posedge clk) begin
    if (rst)                    out_en <= 1'b0;
    else if (nmi_fall || shoot) out_en <= 1'b0;
    else if (en_wr)             out_en <= en_val;
  end

  assert_enable_write_R8: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !nmi_fall && !shoot) |=> (out_en == $past(en_val)));
  assert_nmi_clears_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_fall |=> !out_en);
  assert_shoot_clears_R10: assert property (@(posedge clk) disable iff (rst)
    shoot |=> !out_en);
endmodule

// File: rtl/three_phase_deadtime.sv
module three_phase_deadtime
  import dt_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              tick_raw,
  input  logic              tick_div2,
  input  logic [PHASES-1:0] phase_cmd,
  input  logic              nmi_n,
  input  logic [PHASES-1:0] pad_p_i,
  input  logic [PHASES-1:0] pad_n_i,
  output logic [PHASES-1:0] gate_p_o,
  output logic [PHASES-1:0] gate_n_o,
  output logic              gate_oe
);
  logic [CNT_W-1:0] reload;
  logic             src_div2, protect_en, en_wr, en_val, out_en;
  logic             tick;

  dt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload(reload), .src_div2(src_div2), .protect_en(protect_en),
    .en_wr(en_wr), .en_val(en_val)
  );

  assign tick = src_div2 ? tick_div2 : tick_raw;

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    dt_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst(rst), .cmd(phase_cmd[g]), .tick(tick), .reload(reload),
      .gate_p_o(gate_p_o[g]), .gate_n_o(gate_n_o[g])
    );
  end

  dt_enable_ctrl #(.PHASES(PHASES), .SYNC_STAGES(2)) u_enable (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .pad_p_i(pad_p_i), .pad_n_i(pad_n_i),
    .protect_en(protect_en), .en_wr(en_wr), .en_val(en_val), .out_en(out_en)
  );

  assign gate_oe = out_en;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!gate_oe && (&gate_p_o) && (&gate_n_o)));
endmodule

// File: tb/test_three_phase_deadtime.sv
module test_three_phase_deadtime;
  localparam int PH = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          tick_raw = 1'b1;
  logic          tick_div2 = 1'b0;
  logic [PH-1:0] phase_cmd = '0;
  logic          nmi_n = 1'b1;
  logic [PH-1:0] pad_p_i = '1;
  logic [PH-1:0] pad_n_i = '1;
  logic [PH-1:0] gate_p_o, gate_n_o;
  logic          gate_oe;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  three_phase_deadtime #(.PHASES(PH), .CNT_W(CW)) i_three_phase_deadtime (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_raw(tick_raw), .tick_div2(tick_div2), .phase_cmd(phase_cmd),
    .nmi_n(nmi_n), .pad_p_i(pad_p_i), .pad_n_i(pad_n_i),
    .gate_p_o(gate_p_o), .gate_n_o(gate_n_o), .gate_oe(gate_oe)
  );

  always @(negedge clk) tick_div2 <= ~tick_div2;

  // reference model
  bit     m_cmd[PH];
  bit     m_run[PH];
  int     m_left[PH];
  bit     m_p[PH];
  bit     m_n[PH];
  int     m_reload;
  bit     m_div2, m_prot, m_oe;
  bit     m_nmi[3];

  always @(posedge clk) begin
    bit t, trip, drop;
    if (rst) begin
      for (int i = 0; i < PH; i++) begin
        m_cmd[i] = 0; m_run[i] = 0; m_left[i] = 0; m_p[i] = 1; m_n[i] = 1;
      end
      m_reload = 1; m_div2 = 0; m_prot = 0; m_oe = 0;
      for (int k = 0; k < 3; k++) m_nmi[k] = 1;
    end else begin
      t = m_div2 ? tick_div2 : tick_raw;
      for (int i = 0; i < PH; i++) begin
        m_p[i] = !(m_cmd[i] && !m_run[i]);
        m_n[i] = !(!m_cmd[i] && !m_run[i]);
        if (phase_cmd[i] != m_cmd[i]) begin
          m_cmd[i] = phase_cmd[i]; m_left[i] = m_reload; m_run[i] = 1;
        end else if (m_run[i] && t) begin
          m_left[i] = m_left[i] - 1;
          if (m_left[i] == 0) m_run[i] = 0;
        end
      end
      trip = 0;
      for (int i = 0; i < PH; i++) if (!pad_p_i[i] && !pad_n_i[i]) trip = m_prot;
      drop = m_nmi[2] && !m_nmi[1];
      if (drop || trip) m_oe = 0;
      else if (wr_en && wr_sel) m_oe = wr_data[0];
      if (wr_en && wr_sel) begin m_div2 = wr_data[1]; m_prot = wr_data[2]; end
      if (wr_en && !wr_sel && wr_data != 0) m_reload = int'(wr_data);
      m_nmi[2] = m_nmi[1]; m_nmi[1] = m_nmi[0]; m_nmi[0] = nmi_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < PH; i++) begin
        check(gate_p_o[i] == m_p[i], cur_req, "gate_p", gate_p_o[i], m_p[i]);
        check(gate_n_o[i] == m_n[i], cur_req, "gate_n", gate_n_o[i], m_n[i]);
        check(!(!gate_p_o[i] && !gate_n_o[i]), "R7", "pair overlap",
              {gate_p_o[i], gate_n_o[i]}, 2'b11);
      end
      check(gate_oe == m_oe, cur_req, "gate_oe", gate_oe, m_oe);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  bit done = 0;

  initial begin
    cur_req = "R1";
    cmp_on = 1'b1;
    cyc(4);
    check(gate_oe == 0, "R1", "reset oe", gate_oe, 0);
    check(gate_p_o == '1 && gate_n_o == '1, "R1", "reset gates",
          {gate_p_o, gate_n_o}, 6'h3f);
    rst = 1'b0;
    cyc(3);
    // default reload 1 gives one dead cycle
    cur_req = "R3"; phase_cmd[0] = 1'b1; cyc(5);
    cur_req = "R8"; wr(1'b1, 8'h01); cyc(2);
    check(gate_oe == 1, "R8", "enable write", gate_oe, 1);
    cur_req = "R2"; wr(1'b0, 8'd4); wr(1'b0, 8'd0); cyc(2);
    cur_req = "R3"; phase_cmd[1] = 1'b1; cyc(10);
    check(gate_p_o[1] == 0 && gate_n_o[1] == 1, "R3", "V active after dead time",
          {gate_p_o[1], gate_n_o[1]}, 2'b01);
    cur_req = "R4"; phase_cmd[1] = 1'b0; cyc(3);
    check(gate_p_o[1] == 1 && gate_n_o[1] == 1, "R4", "V both off in dead time",
          {gate_p_o[1], gate_n_o[1]}, 2'b11);
    cyc(6);
    cur_req = "R2"; phase_cmd[2] = 1'b1; cyc(8);
    cur_req = "R5"; wr(1'b0, 8'd6);
    phase_cmd[0] = 1'b0; cyc(3); phase_cmd[0] = 1'b1; cyc(3);
    phase_cmd[0] = 1'b0; cyc(4);
    check(gate_p_o[0] == 1 && gate_n_o[0] == 1, "R5", "U restarted",
          {gate_p_o[0], gate_n_o[0]}, 2'b11);
    cyc(6);
    cur_req = "R6"; wr(1'b1, 8'h03);
    phase_cmd[2] = 1'b0; cyc(16);
    tick_raw = 1'b0; wr(1'b1, 8'h01); phase_cmd[1] = 1'b1; cyc(6);
    check(gate_p_o[1] == 1 && gate_n_o[1] == 1, "R6", "stalled tick holds",
          {gate_p_o[1], gate_n_o[1]}, 2'b11);
    tick_raw = 1'b1; cyc(9);
    cur_req = "R8"; wr(1'b1, 8'h00); cyc(2);
    check(gate_oe == 0, "R8", "disable write", gate_oe, 0);
    wr(1'b1, 8'h01); cyc(2);
    cur_req = "R9"; nmi_n = 1'b0; cyc(2); wr(1'b1, 8'h01); cyc(2);
    check(gate_oe == 0, "R9", "nmi wins over write", gate_oe, 0);
    nmi_n = 1'b1; cyc(4); wr(1'b1, 8'h01); cyc(2);
    cur_req = "R10"; pad_p_i[1] = 1'b0; pad_n_i[1] = 1'b0; cyc(3);
    check(gate_oe == 1, "R10", "protection off ignores pads", gate_oe, 1);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h05; @(negedge clk);
    wr_data = 8'h05; @(negedge clk); wr_en = 1'b0;
    check(gate_oe == 0, "R10", "shoot-through trip", gate_oe, 0);
    pad_p_i = '1; pad_n_i = '1; cyc(2); wr(1'b1, 8'h05); cyc(2);
    check(gate_oe == 1, "R10", "re-enable after trip", gate_oe, 1);
    cur_req = "R1"; rst = 1'b1; cyc(2);
    check(gate_oe == 0 && gate_p_o == '1 && gate_n_o == '1, "R1", "mid-run reset",
          {gate_oe, gate_p_o, gate_n_o}, 7'h3f);
    rst = 1'b0; phase_cmd = '0; cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule